// File: doc/BRIEF.md
# Alternate-Cycle Bus Drive Controller

This block lets a fast host put one data byte, a partial address and a read/write flag onto an external 8-bit processor bus, in step with that bus's E clock, which runs at about 1.5 MHz. The host presents a packed 32-bit word. It then raises either a direct enable or an interrupt-gated arm input. The block samples E in its own system clock and acts on each falling edge of E.

While the block is enabled, its bus drivers are active on every second E cycle and released on the cycles between. On the falling edge that opens an active cycle, the host word is copied into holding registers. The bus outputs show these held values while the drivers are active and are high-impedance otherwise. Dropping the enable stops the sequence only after any active cycle in progress has run to its end.

The arm input is combined with the active-low interrupt line, so the sequence cannot start before the interrupt is asserted. The `busy` output reports the active phase so that the host can poll it.

Top module: `bus_inject`

## Requirements
- R1: A synchronous reset, `rst` high, forces `busy` to 0 and `drv_oe_n` to 1. An enable that is pending when reset is released does not start a cycle until the next falling edge of E.
- R2: E is sampled by two system-clock registers. The phase state changes only on the system clock edge that follows a detected high-to-low transition of E, and holds its value between such edges.
- R3: While a start condition is present, the active phase alternates: `busy` is 1 for one E cycle, 0 for the next E cycle, and so on.
- R4: `drv_oe_n` is the inverse of `busy`. When `busy` is 0, `bus_data`, `bus_addr` and `bus_rw` are high-impedance.
- R5: If the enable is removed during an active cycle, `busy` stays 1 until the next falling edge of E and then goes to 0. No further cycle starts after that.
- R6: The start condition is `dir_en` OR (`irq_arm` AND NOT `irq_n`). When `irq_arm` is high and `irq_n` is high, no cycle starts.
- R7: Field mapping of the host word: `bus_data` = bits 23:16. `bus_addr[3:0]` = bits 10:7 (A0..A3). `bus_addr[4]` = bit 11 (A12). `bus_addr[5]` = bit 12 (A14). `bus_rw` = bit 13.
- R8: The host word is captured on the falling edge of E that starts an active cycle. Changes to `host_word` during that cycle do not change the bus outputs.
- R9: `busy` is 1 exactly while the drivers are active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the E frequency |
| rst | input | 1 | Synchronous reset, active high |
| e_clk | input | 1 | Bus E clock, asynchronous to `clk` |
| host_word | input | 32 | Packed host word holding data, address and R/W |
| dir_en | input | 1 | Direct enable |
| irq_arm | input | 1 | Arm input, gated by the interrupt line |
| irq_n | input | 1 | Bus interrupt line, active low |
| bus_data | output | 8 | Held data byte, tri-stated when idle |
| bus_addr | output | 6 | Held A14, A12 and A3..A0, tri-stated when idle |
| bus_rw | output | 1 | Held read/write flag, tri-stated when idle |
| drv_oe_n | output | 1 | Buffer output enable, active low |
| busy | output | 1 | Active phase flag |

## Verification
A falling edge of E reaches the phase flop two system clock edges after E goes low: one edge for the first sample register, and one for the phase update while the edge is flagged. The bench drives E low on a falling clock edge and samples `busy`, `drv_oe_n` and the bus fields three falling clock edges later, when the update has certainly settled. Checks that a value is held are made between E edges, a few clock cycles after the disturbing input changes, so that the only way an output could move is through the behaviour under test.

// File: rtl/bus_inject.sv
module bus_inject #(
  parameter int DW = 8,
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          e_clk,
  input  logic [31:0]   host_word,
  input  logic          dir_en,
  input  logic          irq_arm,
  input  logic          irq_n,
  output logic [DW-1:0] bus_data,
  output logic [AW-1:0] bus_addr,
  output logic          bus_rw,
  output logic          drv_oe_n,
  output logic          busy
);
  logic e_s1, e_s2, active;
  logic [DW-1:0] hold_d;
  logic [AW-1:0] hold_a;
  logic hold_rw;

  wire e_fall = e_s2 & ~e_s1;
  wire go     = dir_en | (irq_arm & ~irq_n);

  always_ff @(posedge clk) begin
    if (rst) begin
      e_s1   <= 1'b0;
      e_s2   <= 1'b0;
      active <= 1'b0;
    end else begin
      e_s1 <= e_clk;
      e_s2 <= e_s1;
      if (e_fall) active <= ~active & go;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_d  <= '0;
      hold_a  <= '0;
      hold_rw <= 1'b0;
    end else if (e_fall && !active && go) begin
      hold_d  <= host_word[16 +: DW];
      hold_a  <= host_word[7 +: AW];
      hold_rw <= host_word[13];
    end
  end

  assign busy     = active;
  assign drv_oe_n = ~active;
  assign bus_data = active ? hold_d  : 'z;
  assign bus_addr = active ? hold_a  : 'z;
  assign bus_rw   = active ? hold_rw : 1'bz;
endmodule

module bus_inject_chk (
  input logic       clk,
  input logic       rst,
  input logic       e_clk,
  input logic       dir_en,
  input logic       irq_arm,
  input logic       irq_n,
  input logic [7:0] bus_data,
  input logic       busy,
  input logic       drv_oe_n
);
  logic c1, c2;
  always_ff @(posedge clk) begin
    if (rst) begin c1 <= 1'b0; c2 <= 1'b0; end
    else begin c1 <= e_clk; c2 <= c1; end
  end
  wire ef = c2 & ~c1;
  wire st = dir_en | (irq_arm & ~irq_n);

  AST_RESET_IDLE:   assert property (@(posedge clk) rst |=> !busy && drv_oe_n); // R1
  AST_HOLD_BETWEEN: assert property (@(posedge clk) disable iff (rst) !ef |=> $stable(busy)); // R2
  AST_NO_BACK2BACK: assert property (@(posedge clk) disable iff (rst) (ef && busy) |=> !busy); // R3
  AST_NEED_START:   assert property (@(posedge clk) disable iff (rst) (ef && !st) |=> !busy); // R6
  AST_HELD_DATA:    assert property (@(posedge clk) disable iff (rst) (busy && $past(busy)) |-> $stable(bus_data)); // R8
endmodule

bind bus_inject bus_inject_chk u_chk (
  .clk(clk), .rst(rst), .e_clk(e_clk), .dir_en(dir_en), .irq_arm(irq_arm),
  .irq_n(irq_n), .bus_data(bus_data), .busy(busy), .drv_oe_n(drv_oe_n)
);

// File: tb/bus_inject_tb.sv
module bus_inject_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic e_clk = 1'b1;
  logic [31:0] host_word = '0;
  logic dir_en = 1'b0, irq_arm = 1'b0, irq_n = 1'b1;
  logic [7:0] bus_data;
  logic [5:0] bus_addr;
  logic bus_rw, drv_oe_n, busy;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  bus_inject u_dut (
    .clk(clk), .rst(rst), .e_clk(e_clk), .host_word(host_word), .dir_en(dir_en),
    .irq_arm(irq_arm), .irq_n(irq_n), .bus_data(bus_data), .bus_addr(bus_addr),
    .bus_rw(bus_rw), .drv_oe_n(drv_oe_n), .busy(busy)
  );

  // {dir_en, irq_arm, irq_n, expected busy, host_word}
  localparam logic [35:0] VEC [10] = '{
    {4'b1001, 32'h00A5_2F80},
    {4'b1000, 32'h0011_0000},
    {4'b1001, 32'h003C_1500},
    {4'b0000, 32'h00FF_3F80},
    {4'b0000, 32'h0000_0000},
    {4'b0110, 32'h0077_2000},
    {4'b0101, 32'h00C3_1A80},
    {4'b0100, 32'h0000_0000},
    {4'b1111, 32'h005A_0880},
    {4'b0010, 32'h0000_0000}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic e_fall_settle();
    @(negedge clk) e_clk = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic e_rise();
    @(negedge clk) e_clk = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic chk_fields(input logic [31:0] w);
    chk("R7 data", {24'd0, bus_data}, {24'd0, w[23:16]});
    chk("R7 addr", {26'd0, bus_addr}, {26'd0, w[12:7]});
    chk("R7 rw", {31'd0, bus_rw}, {31'd0, w[13]});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    dir_en = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 busy in reset", {31'd0, busy}, 0);
    chk("R1 oe_n in reset", {31'd0, drv_oe_n}, 1);
    @(negedge clk) rst = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 pending enable ignored", {31'd0, busy}, 0);
    dir_en = 1'b0;
    e_rise();

    for (int i = 0; i < 10; i++) begin
      {dir_en, irq_arm, irq_n} = VEC[i][35:33];
      host_word = VEC[i][31:0];
      e_fall_settle();
      chk($sformatf("R3 R6 R9 busy vec%0d", i), {31'd0, busy}, {31'd0, VEC[i][32]});
      chk($sformatf("R4 oe_n vec%0d", i), {31'd0, drv_oe_n}, {31'd0, ~VEC[i][32]});
      if (VEC[i][32]) chk_fields(VEC[i][31:0]);
      e_rise();
    end

    dir_en = 1'b1; irq_arm = 1'b0; host_word = 32'h0099_3480;
    e_fall_settle();
    chk("R9 start", {31'd0, busy}, 1);
    host_word = 32'h0012_0000;
    repeat (3) @(negedge clk);
    chk_fields(32'h0099_3480);
    chk("R8 held data", {24'd0, bus_data}, 32'h99);
    dir_en = 1'b0;
    repeat (3) @(negedge clk);
    chk("R5 busy held after disable", {31'd0, busy}, 1);
    chk("R2 no change without E edge", {31'd0, drv_oe_n}, 0);
    e_rise();
    chk("R2 rising E no effect", {31'd0, busy}, 1);
    e_fall_settle();
    chk("R5 ends at next edge", {31'd0, busy}, 0);
    e_rise();
    e_fall_settle();
    chk("R5 no restart", {31'd0, busy}, 0);
    e_rise();

    dir_en = 1'b1;
    e_fall_settle();
    chk("R1 pre-reset start", {31'd0, busy}, 1);
    @(negedge clk) rst = 1'b1;
    @(negedge clk);
    chk("R1 reset clears busy", {31'd0, busy}, 0);
    chk("R4 reset releases drivers", {31'd0, drv_oe_n}, 1);
    @(negedge clk) rst = 1'b0; dir_en = 1'b0;
    e_rise();

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule